// File: doc/BRIEF.md
# GPIO Output Register Bank with Atomic Aliases

This block holds the pin-control state for two pin banks: a 30-bit main bank and a 6-bit auxiliary bank. Each bank has an output-level register and a direction register. A 1 in the level register drives the pin high and a 0 drives it low. A 1 in the direction register makes the pin an output and a 0 makes it an input. The registers sit behind a simple register-bus slave that has a word address, a write strobe with write data, and a read strobe with read data. The block also reads back the pin levels of both banks through a two-flop synchronizer.

Each of the four registers has four write addresses. One replaces the whole value. The other three change only the bits that are 1 in the write data: one sets them, one clears them and one inverts them. Two masters can each update their own pins through these alias addresses in a single bus write, with no read-modify-write sequence and so no race between them.

Word address map (5-bit address):
- Addresses 0 to 15 hold the registers. Bits [3:2] select the register: 0 is the main level, 1 is the main direction, 2 is the auxiliary level and 3 is the auxiliary direction. Bits [1:0] select the operation: 0 is a direct write, 1 is set, 2 is clear and 3 is toggle.
- Address 16 returns the main-bank inputs.
- Address 17 returns the auxiliary-bank inputs.
- Every other address reads as zero and ignores writes.

Top module: `gpio_out_bank`

## Requirements
- R1: While reset is asserted, and after it is released until the first write, all four registers and all four pin outputs are zero. Every pin therefore starts as an input.
- R2: A write with op 0 loads the write data into the selected register. The new value appears on the outputs after the clock edge on which the write strobe is sampled high.
- R3: A write with op 1 ORs the write data into the selected register.
- R4: A write with op 2 clears each register bit whose write-data bit is 1. Bits whose write-data bit is 0 keep their value.
- R5: A write with op 3 inverts each register bit whose write-data bit is 1. Bits whose write-data bit is 0 keep their value.
- R6: A read of an alias address (op 1, 2 or 3) returns zero.
- R7: A read of address 16 or 17 returns the input level that was present two clock edges earlier. A change on an input pin is not readable after one edge and is readable after the second.
- R8: A write to address 16, 17 or any unmapped address leaves all four registers unchanged.
- R9: A write changes only the register it addresses. The other three registers keep their values.
- R10: In the read data, bits above the bank width are zero: bits [31:30] for the main bank and bits [31:6] for the auxiliary bank. This applies to both direct-register reads and input reads.
- R11: A read of a direct address (op 0) returns the current register value. Read data is zero when the read strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 5 | Word address |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Read data, combinational from address while rd_i is high |
| main_in_i | input | 30 | Main-bank pin levels |
| aux_in_i | input | 6 | Auxiliary-bank pin levels |
| main_out_o | output | 30 | Main-bank output levels |
| main_oe_o | output | 30 | Main-bank output enables |
| aux_out_o | output | 6 | Auxiliary-bank output levels |
| aux_oe_o | output | 6 | Auxiliary-bank output enables |

## Verification
Each register write takes effect on the one rising edge at which the strobe is sampled. The bench therefore drives writes on a falling edge, drops the strobe on the next falling edge, and compares the pin outputs there, half a cycle after the update. Read data is combinational within the cycle, so each read is sampled a short delay after its address is applied and before the next rising edge. For input readback, the bench changes a pin on a falling edge and reads once after the first rising edge, where it expects the old value, and again after the second, where it expects the new one.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned ADDR_W   = 5;
  localparam int unsigned MAIN_W   = 30;
  localparam int unsigned AUX_W    = 6;
  localparam int unsigned NUM_REGS = 4;
  localparam int unsigned REG_IDX_W = $clog2(NUM_REGS);

  // register index order (addr[3:2])
  localparam int unsigned REG_MAIN_OUT = 0;
  localparam int unsigned REG_MAIN_OE  = 1;
  localparam int unsigned REG_AUX_OUT  = 2;
  localparam int unsigned REG_AUX_OE   = 3;

  localparam int unsigned ALIAS_SPAN   = NUM_REGS * 4;
  localparam int unsigned ADDR_IN_MAIN = ALIAS_SPAN;
  localparam int unsigned ADDR_IN_AUX  = ALIAS_SPAN + 1;

  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_SET   = 2'd1,
    OP_CLR   = 2'd2,
    OP_XOR   = 2'd3
  } alias_op_e;
endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
  import gpio_bank_pkg::*;
#(
  parameter int unsigned AW = ADDR_W
) (
  input  logic [AW-1:0]        addr_i,
  input  logic                 wr_i,
  output logic [NUM_REGS-1:0]  we_o,
  output alias_op_e            op_o,
  output logic [REG_IDX_W-1:0] reg_idx_o,
  output logic                 rd_direct_o,
  output logic                 rd_in_main_o,
  output logic                 rd_in_aux_o
);
  logic in_alias;

  assign in_alias  = (addr_i < AW'(ALIAS_SPAN));
  assign op_o      = alias_op_e'(addr_i[1:0]);
  assign reg_idx_o = addr_i[2 +: REG_IDX_W];

  always_comb begin
    we_o = '0;
    if (wr_i && in_alias) we_o[reg_idx_o] = 1'b1;
  end

  assign rd_direct_o  = in_alias && (op_o == OP_WRITE);
  assign rd_in_main_o = (addr_i == AW'(ADDR_IN_MAIN));
  assign rd_in_aux_o  = (addr_i == AW'(ADDR_IN_AUX));
endmodule

// File: rtl/gpio_alias_reg.sv
module gpio_alias_reg
  import gpio_bank_pkg::*;
#(
  parameter int unsigned W = MAIN_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  alias_op_e    op_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o <= '0;
    end else if (we_i) begin
      unique case (op_i)
        OP_WRITE: q_o <= wdata_i;
        OP_SET:   q_o <= q_o | wdata_i;
        OP_CLR:   q_o <= q_o & ~wdata_i;
        OP_XOR:   q_o <= q_o ^ wdata_i;
        default:  q_o <= q_o;
      endcase
    end
  end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned W      = 30,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_out_bank.sv
module gpio_out_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned DW      = DATA_W,
  parameter int unsigned AW      = ADDR_W,
  parameter int unsigned MW      = MAIN_W,
  parameter int unsigned XW      = AUX_W,
  parameter int unsigned SYNC_ST = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rd_i,
  output logic [DW-1:0] rdata_o,
  input  logic [MW-1:0] main_in_i,
  input  logic [XW-1:0] aux_in_i,
  output logic [MW-1:0] main_out_o,
  output logic [MW-1:0] main_oe_o,
  output logic [XW-1:0] aux_out_o,
  output logic [XW-1:0] aux_oe_o
);
  logic [NUM_REGS-1:0]  we;
  alias_op_e            op;
  logic [REG_IDX_W-1:0] reg_idx;
  logic                 rd_direct, rd_in_main, rd_in_aux;
  logic [DW-1:0]        reg_q [NUM_REGS];
  logic [MW-1:0]        main_sync;
  logic [XW-1:0]        aux_sync;
  logic                 unused_wdata;

  assign unused_wdata = ^wdata_i;

  gpio_addr_decode #(.AW(AW)) u_dec (
    .addr_i       (addr_i),
    .wr_i         (wr_i),
    .we_o         (we),
    .op_o         (op),
    .reg_idx_o    (reg_idx),
    .rd_direct_o  (rd_direct),
    .rd_in_main_o (rd_in_main),
    .rd_in_aux_o  (rd_in_aux)
  );

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam int unsigned RW = (i < 2) ? MW : XW;
    logic [RW-1:0] q;

    gpio_alias_reg #(.W(RW)) u_reg (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (we[i]),
      .op_i    (op),
      .wdata_i (wdata_i[RW-1:0]),
      .q_o     (q)
    );
    assign reg_q[i] = DW'(q);
  end

  gpio_in_sync #(.W(MW), .STAGES(SYNC_ST)) u_sync_main (
    .clk_i (clk_i), .rst_ni (rst_ni), .d_i (main_in_i), .q_o (main_sync)
  );

  gpio_in_sync #(.W(XW), .STAGES(SYNC_ST)) u_sync_aux (
    .clk_i (clk_i), .rst_ni (rst_ni), .d_i (aux_in_i), .q_o (aux_sync)
  );

  assign main_out_o = reg_q[REG_MAIN_OUT][MW-1:0];
  assign main_oe_o  = reg_q[REG_MAIN_OE][MW-1:0];
  assign aux_out_o  = reg_q[REG_AUX_OUT][XW-1:0];
  assign aux_oe_o   = reg_q[REG_AUX_OE][XW-1:0];

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      if (rd_direct)       rdata_o = reg_q[reg_idx];
      else if (rd_in_main) rdata_o = DW'(main_sync);
      else if (rd_in_aux)  rdata_o = DW'(aux_sync);
    end
  end
endmodule

// File: rtl/gpio_out_bank_chk.sv
module gpio_out_bank_chk #(
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 5,
  parameter int unsigned MW = 30,
  parameter int unsigned XW = 6
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [AW-1:0] addr_i,
  input logic          wr_i,
  input logic [DW-1:0] wdata_i,
  input logic          rd_i,
  input logic [DW-1:0] rdata_o,
  input logic [MW-1:0] main_in_i,
  input logic [XW-1:0] aux_in_i,
  input logic [MW-1:0] main_out_o,
  input logic [MW-1:0] main_oe_o,
  input logic [XW-1:0] aux_out_o,
  input logic [XW-1:0] aux_oe_o
);
  logic       in_alias;
  logic [1:0] op, rg;
  logic [1:0] cyc;
  logic       unused_chk;

  assign in_alias   = addr_i < AW'(16);
  assign op         = addr_i[1:0];
  assign rg         = addr_i[3:2];
  assign unused_chk = ^aux_in_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cyc <= '0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end

  a_r1_reset_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc == 2'd0) |-> (main_out_o == '0 && main_oe_o == '0 && aux_out_o == '0 && aux_oe_o == '0));

  a_r3_set_keeps_ones: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && in_alias && rg == 2'd0 && op == 2'd1)
    |=> ((main_out_o & $past(main_out_o)) == $past(main_out_o)));

  a_r4_clear_drops_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && in_alias && rg == 2'd0 && op == 2'd2)
    |=> ((main_out_o & $past(wdata_i[MW-1:0])) == '0));

  a_r5_toggle_oe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && in_alias && rg == 2'd1 && op == 2'd3)
    |=> (main_oe_o == ($past(main_oe_o) ^ $past(wdata_i[MW-1:0]))));

  a_r6_alias_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && in_alias && op != 2'd0) |-> (rdata_o == '0));

  a_r7_input_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc == 2'd3 && rd_i && addr_i == AW'(16)) |-> (rdata_o[MW-1:0] == $past(main_in_i, 2)));

  a_r8_input_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !in_alias)
    |=> ($stable(main_out_o) && $stable(main_oe_o) && $stable(aux_out_o) && $stable(aux_oe_o)));

  a_r9_other_regs_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && in_alias && rg == 2'd2)
    |=> ($stable(main_out_o) && $stable(main_oe_o) && $stable(aux_oe_o)));

  a_r10_aux_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == AW'(17)) |-> (rdata_o[DW-1:XW] == '0));
endmodule

bind gpio_out_bank gpio_out_bank_chk #(.DW(DW), .AW(AW), .MW(MW), .XW(XW)) u_chk (.*);

// File: tb/tb_gpio_out_bank.sv
`timescale 1ns/100ps
module tb_gpio_out_bank;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [4:0]  addr_i = '0;
  logic        wr_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic        rd_i = 1'b0;
  logic [31:0] rdata_o;
  logic [29:0] main_in_i = '0;
  logic [5:0]  aux_in_i = '0;
  logic [29:0] main_out_o, main_oe_o;
  logic [5:0]  aux_out_o, aux_oe_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2.5 clk_i = ~clk_i;

  gpio_out_bank dut (.*);

  typedef struct packed {
    logic [4:0]  addr;
    logic [31:0] data;
    logic [29:0] mo;
    logic [29:0] moe;
    logic [5:0]  ao;
    logic [5:0]  aoe;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{5'd0,  32'hFFFF_FFFF, 30'h3FFF_FFFF, 30'h0,         6'h00, 6'h00, 4'd2},  // R2
    '{5'd2,  32'h0000_FFFF, 30'h3FFF_0000, 30'h0,         6'h00, 6'h00, 4'd4},  // R4
    '{5'd1,  32'h0000_00A5, 30'h3FFF_00A5, 30'h0,         6'h00, 6'h00, 4'd3},  // R3
    '{5'd3,  32'h3000_00FF, 30'h0FFF_005A, 30'h0,         6'h00, 6'h00, 4'd5},  // R5
    '{5'd4,  32'h1234_5678, 30'h0FFF_005A, 30'h1234_5678, 6'h00, 6'h00, 4'd2},  // R2
    '{5'd7,  32'hFFFF_FFFF, 30'h0FFF_005A, 30'h2DCB_A987, 6'h00, 6'h00, 4'd9},  // R9
    '{5'd8,  32'h0000_00FF, 30'h0FFF_005A, 30'h2DCB_A987, 6'h3F, 6'h00, 4'd2},  // R2
    '{5'd10, 32'h0000_0005, 30'h0FFF_005A, 30'h2DCB_A987, 6'h3A, 6'h00, 4'd4},  // R4
    '{5'd13, 32'h0000_0011, 30'h0FFF_005A, 30'h2DCB_A987, 6'h3A, 6'h11, 4'd3},  // R3
    '{5'd15, 32'h0000_003F, 30'h0FFF_005A, 30'h2DCB_A987, 6'h3A, 6'h2E, 4'd5},  // R5
    '{5'd16, 32'hFFFF_FFFF, 30'h0FFF_005A, 30'h2DCB_A987, 6'h3A, 6'h2E, 4'd8},  // R8
    '{5'd20, 32'hFFFF_FFFF, 30'h0FFF_005A, 30'h2DCB_A987, 6'h3A, 6'h2E, 4'd8}   // R8
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic bus_rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk_i);
    addr_i = a; rd_i = 1'b1;
    #1 d = rdata_o;
    rd_i = 1'b0;
  endtask

  task automatic chk_pins(input string req, input logic [29:0] mo, input logic [29:0] moe,
                          input logic [5:0] ao, input logic [5:0] aoe);
    chk(req, 32'(main_out_o), 32'(mo));
    chk(req, 32'(main_oe_o),  32'(moe));
    chk(req, 32'(aux_out_o),  32'(ao));
    chk(req, 32'(aux_oe_o),   32'(aoe));
  endtask

  initial begin
    logic [31:0] r;
    #1;
    chk_pins("R1 in reset", '0, '0, '0, '0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk_pins("R1 after release", '0, '0, '0, '0);
    bus_rd(5'd0, r);  chk("R1 read main out", r, 32'h0);
    bus_rd(5'd12, r); chk("R1 read aux oe", r, 32'h0);

    for (int i = 0; i < NV; i++) begin
      bus_wr(VECS[i].addr, VECS[i].data);
      chk_pins($sformatf("R%0d vec %0d", VECS[i].req, i),
               VECS[i].mo, VECS[i].moe, VECS[i].ao, VECS[i].aoe);
    end

    // R11 direct readback, R10 upper bits zero
    bus_rd(5'd0, r);  chk("R11 read main out", r, 32'h0FFF_005A);
    bus_rd(5'd4, r);  chk("R11 read main oe", r, 32'h2DCB_A987);
    bus_rd(5'd8, r);  chk("R10 read aux out", r, 32'h0000_003A);
    bus_rd(5'd12, r); chk("R10 read aux oe", r, 32'h0000_002E);
    // R6 alias reads are zero
    bus_rd(5'd1, r);  chk("R6 read set alias", r, 32'h0);
    bus_rd(5'd7, r);  chk("R6 read toggle alias", r, 32'h0);
    bus_rd(5'd14, r); chk("R6 read clear alias", r, 32'h0);
    bus_rd(5'd21, r); chk("R6 read unmapped", r, 32'h0);
    // R11 no read strobe -> zero
    @(negedge clk_i); addr_i = 5'd4; rd_i = 1'b0;
    #1 chk("R11 strobe low", rdata_o, 32'h0);

    // R7 input latency, main bank
    @(negedge clk_i); main_in_i = 30'h2AAA_AAAA; aux_in_i = 6'h25;
    addr_i = 5'd16; rd_i = 1'b1;
    @(negedge clk_i); #1 chk("R7 main after one edge", rdata_o, 32'h0);
    @(negedge clk_i); #1 chk("R7 main after two edges", rdata_o, 32'h2AAA_AAAA);
    addr_i = 5'd17;
    #1 chk("R7 aux after two edges", rdata_o, 32'h0000_0025);
    rd_i = 1'b0;
    @(negedge clk_i); main_in_i = 30'h3FFF_FFFF; aux_in_i = 6'h3F;
    repeat (2) @(negedge clk_i);
    bus_rd(5'd16, r); chk("R10 main input upper zero", r, 32'h3FFF_FFFF);
    bus_rd(5'd17, r); chk("R10 aux input upper zero", r, 32'h0000_003F);
    chk_pins("R8 inputs do not touch regs", 30'h0FFF_005A, 30'h2DCB_A987, 6'h3A, 6'h2E);

    // R9 toggle aux out only
    bus_wr(5'd11, 32'hFFFF_FFFF);
    chk_pins("R9 aux out toggle", 30'h0FFF_005A, 30'h2DCB_A987, 6'h05, 6'h2E);

    // R1 reset mid-run
    @(negedge clk_i); rst_ni = 1'b0;
    #1 chk_pins("R1 mid-run reset", '0, '0, '0, '0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i);
    bus_rd(5'd4, r); chk("R1 read oe after reset", r, 32'h0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule